// File: doc/BRIEF.md
# Three-level trap delegation router

This block is the privilege and trap-routing core of a hart that supports machine (M), supervisor (S) and user (U) modes. Each cycle it accepts at most one control event: a trap request (interrupt flag, cause, PC, trap value), an M-level return or an S-level return. For a trap it decides whether the handler runs in M-mode or in S-mode, updates the privilege stack and the cause, exception PC and trap-value registers of the chosen level, and gives the handler address. For a return it checks that the current privilege allows it, then restores the saved privilege and interrupt enable and redirects to the saved exception PC. A return that is not allowed becomes an illegal-instruction trap, and that trap is routed like any other.

Per-cause delegation masks decide the routing: one mask for exceptions and one for interrupts. A set bit sends that cause to S-mode, but only for traps taken while running in S or U. The block also holds the small set of trap CSRs and reads them combinationally through one address port. The event inputs are single-cycle strobes. The block is always ready, so there is no back-pressure. The redirect output is valid in the same cycle as the event, and the new privilege and CSR contents appear after the next clock edge.

Top module: `trap_deleg_router`

## Requirements
- R1: After reset the privilege output is M (2'b11), redirect_valid is low, and every CSR reads zero.
- R2: A trap taken in S or U whose cause bit is set in the exception mask (CSR 0x302, when trap_irq=0) or in the interrupt mask (CSR 0x303, when trap_irq=1) enters S (2'b01). It redirects to the S handler base (CSR 0x105). sepc (0x141) gets evt_pc, stval (0x143) gets trap_tval, and scause (0x142) gets the cause, with bit XLEN-1 set for interrupts.
- R3: A trap delegated to S leaves mepc (0x341), mcause (0x342), mtval (0x343) and the M stack fields unchanged.
- R4: A trap whose cause bit is clear, and any trap taken in M regardless of the masks, enters M. It redirects to the M handler base (0x305) and fills mepc, mcause and mtval. In mstatus (0x300), MPP (bits 12:11) gets the prior privilege, MPIE (bit 7) gets MIE (bit 3), and MIE is cleared.
- R5: On a delegated trap, SPP (bit 8) becomes 1 if the trap came from S and 0 if it came from U. SPIE (bit 5) gets SIE (bit 1), and SIE is cleared.
- R6: mret in M redirects to mepc and sets privilege to MPP. It also sets MIE to MPIE, MPIE to 1 and MPP to U (00).
- R7: sret in S or M redirects to sepc and sets privilege to S if SPP=1, else U. It also sets SIE to SPIE, SPIE to 1 and SPP to 0.
- R8: These returns are illegal: sret in U, sret in S while TSR (mstatus bit 22) is set, and mret outside M. An illegal return raises an illegal-instruction trap with cause 2, epc = evt_pc and tval 0, routed by the R2/R4 rules.
- R9: A write to mstatus that carries MPP = 2'b10 keeps the previous MPP, and the other fields in the same write still take effect.
- R10: sstatus (0x100) reads mstatus masked to bits 1, 5 and 8. A write to sstatus changes only those three bits.
- R11: A trap request wins over both return strobes in the same cycle, and mret wins over sret. A CSR write in a cycle that carries any event is dropped.
- R12: The two low bits of either handler-base register do not affect the redirect address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Trap request strobe |
| trap_irq | input | 1 | 1 = interrupt, 0 = exception |
| trap_cause | input | CAUSE_W | Cause code |
| evt_pc | input | XLEN | PC of the trapping or returning instruction |
| trap_tval | input | XLEN | Trap value |
| mret_req | input | 1 | M-level return strobe |
| sret_req | input | 1 | S-level return strobe |
| csr_we | input | 1 | CSR write enable |
| csr_addr | input | 12 | CSR address for read and write |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data (combinational) |
| priv_o | output | 2 | Current privilege (00 U, 01 S, 11 M) |
| redirect_valid | output | 1 | A trap or return redirects fetch this cycle |
| redirect_pc | output | XLEN | Redirect target |

## Verification
If the privilege register or a stack bit is wrong, the next return or trap shows it. The return redirects to the wrong EPC or lands in the wrong mode, and a mis-saved SPP or MPP is visible one cycle after the trap through the status CSR. A wrong routing decision shows in the same cycle: redirect_pc points at the other level's handler base, and the other level's cause register is written one edge later. The directed sequence walks M→S→U and back along every path, so a corrupted bit shows up within one or two events of the fault.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_M = 2'b11
  } priv_e;

  typedef enum logic [1:0] {
    EV_NONE,
    EV_TRAP,
    EV_MRET,
    EV_SRET
  } ev_e;

  localparam logic [11:0] A_SSTATUS = 12'h100;
  localparam logic [11:0] A_STVEC   = 12'h105;
  localparam logic [11:0] A_SEPC    = 12'h141;
  localparam logic [11:0] A_SCAUSE  = 12'h142;
  localparam logic [11:0] A_STVAL   = 12'h143;
  localparam logic [11:0] A_MSTATUS = 12'h300;
  localparam logic [11:0] A_EXCMASK = 12'h302;
  localparam logic [11:0] A_IRQMASK = 12'h303;
  localparam logic [11:0] A_MTVEC   = 12'h305;
  localparam logic [11:0] A_MEPC    = 12'h341;
  localparam logic [11:0] A_MCAUSE  = 12'h342;
  localparam logic [11:0] A_MTVAL   = 12'h343;

  localparam int B_SIE  = 1;
  localparam int B_MIE  = 3;
  localparam int B_SPIE = 5;
  localparam int B_MPIE = 7;
  localparam int B_SPP  = 8;
  localparam int B_MPP  = 11;
  localparam int B_TSR  = 22;

  localparam int CAUSE_ILLEGAL = 2;
endpackage

// File: rtl/tdr_decide.sv
module tdr_decide
  import tdr_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5,
  localparam int NCAUSE = 1 << CAUSE_W
) (
  input  priv_e               priv,
  input  logic                tsr,
  input  logic                trap_req,
  input  logic                trap_irq,
  input  logic [CAUSE_W-1:0]  trap_cause,
  input  logic [XLEN-1:0]     trap_tval,
  input  logic                mret_req,
  input  logic                sret_req,
  input  logic [NCAUSE-1:0]   exc_mask,
  input  logic [NCAUSE-1:0]   irq_mask,
  input  logic [XLEN-1:0]     tvec_m,
  input  logic [XLEN-1:0]     tvec_s,
  input  logic [XLEN-1:0]     epc_m,
  input  logic [XLEN-1:0]     epc_s,
  output ev_e                 ev,
  output logic                to_s,
  output logic                irq_o,
  output logic [CAUSE_W-1:0]  cause_o,
  output logic [XLEN-1:0]     tval_o,
  output logic [XLEN-1:0]     target
);
  localparam logic [XLEN-1:0] BASE_MASK = ~XLEN'(3);

  logic mret_bad, sret_bad, mask_hit;

  assign mret_bad = (priv != PRIV_M);
  assign sret_bad = (priv == PRIV_U) || ((priv == PRIV_S) && tsr);

  always_comb begin
    ev      = EV_NONE;
    irq_o   = 1'b0;
    cause_o = '0;
    tval_o  = '0;
    if (trap_req) begin
      ev      = EV_TRAP;
      irq_o   = trap_irq;
      cause_o = trap_cause;
      tval_o  = trap_tval;
    end else if (mret_req) begin
      if (mret_bad) begin
        ev      = EV_TRAP;
        cause_o = CAUSE_W'(CAUSE_ILLEGAL);
      end else begin
        ev = EV_MRET;
      end
    end else if (sret_req) begin
      if (sret_bad) begin
        ev      = EV_TRAP;
        cause_o = CAUSE_W'(CAUSE_ILLEGAL);
      end else begin
        ev = EV_SRET;
      end
    end
  end

  assign mask_hit = irq_o ? irq_mask[cause_o] : exc_mask[cause_o];
  assign to_s     = (ev == EV_TRAP) && (priv != PRIV_M) && mask_hit;

  always_comb begin
    unique case (ev)
      EV_TRAP: target = (to_s ? tvec_s : tvec_m) & BASE_MASK;
      EV_MRET: target = epc_m;
      EV_SRET: target = epc_s;
      default: target = '0;
    endcase
  end
endmodule

// File: rtl/tdr_state.sv
module tdr_state
  import tdr_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5,
  localparam int NCAUSE = 1 << CAUSE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ev_e                 ev,
  input  logic                to_s,
  input  logic                irq,
  input  logic [CAUSE_W-1:0]  cause,
  input  logic [XLEN-1:0]     epc_in,
  input  logic [XLEN-1:0]     tval,
  input  logic                csr_we,
  input  logic [11:0]         csr_addr,
  input  logic [XLEN-1:0]     csr_wdata,
  output priv_e               priv_q,
  output logic                sie_q, mie_q, spie_q, mpie_q, spp_q, tsr_q,
  output priv_e               mpp_q,
  output logic [NCAUSE-1:0]   exc_mask_q,
  output logic [NCAUSE-1:0]   irq_mask_q,
  output logic [XLEN-1:0]     mtvec_q, stvec_q,
  output logic [XLEN-1:0]     mepc_q, sepc_q,
  output logic [XLEN-1:0]     mcause_q, scause_q,
  output logic [XLEN-1:0]     mtval_q, stval_q
);
  logic [XLEN-1:0] cause_word;

  always_comb begin
    cause_word                = '0;
    cause_word[CAUSE_W-1:0]   = cause;
    cause_word[XLEN-1]        = irq;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      priv_q     <= PRIV_M;
      mpp_q      <= PRIV_U;
      sie_q      <= 1'b0;
      mie_q      <= 1'b0;
      spie_q     <= 1'b0;
      mpie_q     <= 1'b0;
      spp_q      <= 1'b0;
      tsr_q      <= 1'b0;
      exc_mask_q <= '0;
      irq_mask_q <= '0;
      mtvec_q    <= '0;
      stvec_q    <= '0;
      mepc_q     <= '0;
      sepc_q     <= '0;
      mcause_q   <= '0;
      scause_q   <= '0;
      mtval_q    <= '0;
      stval_q    <= '0;
    end else begin
      unique case (ev)
        EV_TRAP: begin
          if (to_s) begin
            sepc_q   <= epc_in;
            scause_q <= cause_word;
            stval_q  <= tval;
            spp_q    <= (priv_q == PRIV_S);
            spie_q   <= sie_q;
            sie_q    <= 1'b0;
            priv_q   <= PRIV_S;
          end else begin
            mepc_q   <= epc_in;
            mcause_q <= cause_word;
            mtval_q  <= tval;
            mpp_q    <= priv_q;
            mpie_q   <= mie_q;
            mie_q    <= 1'b0;
            priv_q   <= PRIV_M;
          end
        end
        EV_MRET: begin
          priv_q <= mpp_q;
          mie_q  <= mpie_q;
          mpie_q <= 1'b1;
          mpp_q  <= PRIV_U;
        end
        EV_SRET: begin
          priv_q <= spp_q ? PRIV_S : PRIV_U;
          sie_q  <= spie_q;
          spie_q <= 1'b1;
          spp_q  <= 1'b0;
        end
        default: begin
          if (csr_we) begin
            unique case (csr_addr)
              A_MSTATUS: begin
                sie_q  <= csr_wdata[B_SIE];
                mie_q  <= csr_wdata[B_MIE];
                spie_q <= csr_wdata[B_SPIE];
                mpie_q <= csr_wdata[B_MPIE];
                spp_q  <= csr_wdata[B_SPP];
                tsr_q  <= csr_wdata[B_TSR];
                if (csr_wdata[B_MPP+1 -: 2] != 2'b10)
                  mpp_q <= priv_e'(csr_wdata[B_MPP+1 -: 2]);
              end
              A_SSTATUS: begin
                sie_q  <= csr_wdata[B_SIE];
                spie_q <= csr_wdata[B_SPIE];
                spp_q  <= csr_wdata[B_SPP];
              end
              A_EXCMASK: exc_mask_q <= csr_wdata[NCAUSE-1:0];
              A_IRQMASK: irq_mask_q <= csr_wdata[NCAUSE-1:0];
              A_MTVEC:   mtvec_q    <= csr_wdata;
              A_STVEC:   stvec_q    <= csr_wdata;
              A_MEPC:    mepc_q     <= csr_wdata;
              A_SEPC:    sepc_q     <= csr_wdata;
              A_MCAUSE:  mcause_q   <= csr_wdata;
              A_SCAUSE:  scause_q   <= csr_wdata;
              A_MTVAL:   mtval_q    <= csr_wdata;
              A_STVAL:   stval_q    <= csr_wdata;
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  // R9: the reserved privilege code never reaches the saved M stack
  a_r9_mpp_never_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    mpp_q != 2'b10);

  // R3: a trap routed to S leaves the M-level record untouched
  a_r3_deleg_keeps_m: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_TRAP && to_s) |=> ($stable(mepc_q) && $stable(mcause_q) && $stable(mtval_q) && $stable(mpp_q)));

  // R5: a delegated trap lands in S with SIE masked
  a_r5_deleg_masks_sie: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_TRAP && to_s) |=> (!sie_q && priv_q == PRIV_S));

  // R6: mret re-arms MPIE and resets MPP to U
  a_r6_mret_resets_stack: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_MRET) |=> (mpp_q == PRIV_U && mpie_q));

  // R7: sret re-arms SPIE and clears SPP
  a_r7_sret_resets_stack: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_SRET) |=> (!spp_q && spie_q));
endmodule

// File: rtl/tdr_csr_rd.sv
module tdr_csr_rd
  import tdr_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5,
  localparam int NCAUSE = 1 << CAUSE_W
) (
  input  logic [11:0]        addr,
  input  logic               sie, mie, spie, mpie, spp, tsr,
  input  priv_e              mpp,
  input  logic [NCAUSE-1:0]  exc_mask,
  input  logic [NCAUSE-1:0]  irq_mask,
  input  logic [XLEN-1:0]    mtvec, stvec, mepc, sepc,
  input  logic [XLEN-1:0]    mcause, scause, mtval, stval,
  output logic [XLEN-1:0]    rdata
);
  logic [XLEN-1:0] mstatus_img, sstatus_img;

  always_comb begin
    mstatus_img               = '0;
    mstatus_img[B_SIE]        = sie;
    mstatus_img[B_MIE]        = mie;
    mstatus_img[B_SPIE]       = spie;
    mstatus_img[B_MPIE]       = mpie;
    mstatus_img[B_SPP]        = spp;
    mstatus_img[B_MPP+1 -: 2] = mpp;
    mstatus_img[B_TSR]        = tsr;
    sstatus_img               = '0;
    sstatus_img[B_SIE]        = sie;
    sstatus_img[B_SPIE]       = spie;
    sstatus_img[B_SPP]        = spp;
  end

  always_comb begin
    unique case (addr)
      A_MSTATUS: rdata = mstatus_img;
      A_SSTATUS: rdata = sstatus_img;
      A_EXCMASK: rdata = XLEN'(exc_mask);
      A_IRQMASK: rdata = XLEN'(irq_mask);
      A_MTVEC:   rdata = mtvec;
      A_STVEC:   rdata = stvec;
      A_MEPC:    rdata = mepc;
      A_SEPC:    rdata = sepc;
      A_MCAUSE:  rdata = mcause;
      A_SCAUSE:  rdata = scause;
      A_MTVAL:   rdata = mtval;
      A_STVAL:   rdata = stval;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/trap_deleg_router.sv
module trap_deleg_router
  import tdr_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trap_req,
  input  logic               trap_irq,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic [XLEN-1:0]    evt_pc,
  input  logic [XLEN-1:0]    trap_tval,
  input  logic               mret_req,
  input  logic               sret_req,
  input  logic               csr_we,
  input  logic [11:0]        csr_addr,
  input  logic [XLEN-1:0]    csr_wdata,
  output logic [XLEN-1:0]    csr_rdata,
  output logic [1:0]         priv_o,
  output logic               redirect_valid,
  output logic [XLEN-1:0]    redirect_pc
);
  localparam int NCAUSE = 1 << CAUSE_W;

  ev_e                ev;
  logic               to_s, irq_d;
  logic [CAUSE_W-1:0] cause_d;
  logic [XLEN-1:0]    tval_d;
  priv_e              priv_q, mpp_q;
  logic               sie_q, mie_q, spie_q, mpie_q, spp_q, tsr_q;
  logic [NCAUSE-1:0]  exc_mask_q, irq_mask_q;
  logic [XLEN-1:0]    mtvec_q, stvec_q, mepc_q, sepc_q;
  logic [XLEN-1:0]    mcause_q, scause_q, mtval_q, stval_q;

  tdr_decide #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_decide (
    .priv(priv_q), .tsr(tsr_q),
    .trap_req(trap_req), .trap_irq(trap_irq), .trap_cause(trap_cause),
    .trap_tval(trap_tval), .mret_req(mret_req), .sret_req(sret_req),
    .exc_mask(exc_mask_q), .irq_mask(irq_mask_q),
    .tvec_m(mtvec_q), .tvec_s(stvec_q), .epc_m(mepc_q), .epc_s(sepc_q),
    .ev(ev), .to_s(to_s), .irq_o(irq_d), .cause_o(cause_d),
    .tval_o(tval_d), .target(redirect_pc)
  );

  tdr_state #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_state (
    .clk(clk), .rst_n(rst_n), .ev(ev), .to_s(to_s), .irq(irq_d),
    .cause(cause_d), .epc_in(evt_pc), .tval(tval_d),
    .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .priv_q(priv_q), .sie_q(sie_q), .mie_q(mie_q), .spie_q(spie_q),
    .mpie_q(mpie_q), .spp_q(spp_q), .tsr_q(tsr_q), .mpp_q(mpp_q),
    .exc_mask_q(exc_mask_q), .irq_mask_q(irq_mask_q),
    .mtvec_q(mtvec_q), .stvec_q(stvec_q), .mepc_q(mepc_q), .sepc_q(sepc_q),
    .mcause_q(mcause_q), .scause_q(scause_q), .mtval_q(mtval_q), .stval_q(stval_q)
  );

  tdr_csr_rd #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_rd (
    .addr(csr_addr), .sie(sie_q), .mie(mie_q), .spie(spie_q), .mpie(mpie_q),
    .spp(spp_q), .tsr(tsr_q), .mpp(mpp_q),
    .exc_mask(exc_mask_q), .irq_mask(irq_mask_q),
    .mtvec(mtvec_q), .stvec(stvec_q), .mepc(mepc_q), .sepc(sepc_q),
    .mcause(mcause_q), .scause(scause_q), .mtval(mtval_q), .stval(stval_q),
    .rdata(csr_rdata)
  );

  assign priv_o         = priv_q;
  assign redirect_valid = (ev != EV_NONE);

  // R4: a trap raised while in M is never handed to S
  a_r4_m_traps_stay_m: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && priv_o == 2'b11) |=> (priv_o == 2'b11));

  // R8: sret attempted in U leaves U through a trap
  a_r8_sret_in_u_traps: assert property (@(posedge clk) disable iff (!rst_n)
    (sret_req && !trap_req && !mret_req && priv_o == 2'b00) |=> (priv_o != 2'b00));

  // R1: privilege output never shows the reserved code
  a_r1_priv_legal: assert property (@(posedge clk) disable iff (!rst_n)
    priv_o != 2'b10);
endmodule

// File: tb/trap_deleg_router_bench.sv
`timescale 1ns/1ps
module trap_deleg_router_bench;
  localparam int XLEN = 32;
  localparam int CW   = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            trap_req = 0, trap_irq = 0, mret_req = 0, sret_req = 0, csr_we = 0;
  logic [CW-1:0]   trap_cause = '0;
  logic [XLEN-1:0] evt_pc = '0, trap_tval = '0, csr_wdata = '0;
  logic [11:0]     csr_addr = '0;
  logic [XLEN-1:0] csr_rdata, redirect_pc;
  logic [1:0]      priv_o;
  logic            redirect_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  trap_deleg_router #(.XLEN(XLEN), .CAUSE_W(CW)) u_trap_deleg_router (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_irq(trap_irq),
    .trap_cause(trap_cause), .evt_pc(evt_pc), .trap_tval(trap_tval),
    .mret_req(mret_req), .sret_req(sret_req), .csr_we(csr_we),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .priv_o(priv_o), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
  );

  task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, input logic [XLEN-1:0] exp, input string tag);
    @(negedge clk);
    csr_we = 0; csr_addr = a;
    #1 chk(tag, csr_rdata, exp);
  endtask

  task automatic wr(input logic [11:0] a, input logic [XLEN-1:0] d);
    @(negedge clk);
    csr_we = 1; csr_addr = a; csr_wdata = d;
    @(posedge clk); #1 csr_we = 0;
  endtask

  task automatic ev(input bit t, input bit irq, input int cause, input logic [XLEN-1:0] pc,
                    input logic [XLEN-1:0] tv, input bit mr, input bit sr,
                    input logic [XLEN-1:0] exp_pc, input string tag);
    @(negedge clk);
    trap_req = t; trap_irq = irq; trap_cause = CW'(cause); evt_pc = pc;
    trap_tval = tv; mret_req = mr; sret_req = sr;
    #1;
    chk({tag, " redirect_valid"}, XLEN'(redirect_valid), 1);
    chk({tag, " redirect_pc"}, redirect_pc, exp_pc);
    @(posedge clk); #1;
    trap_req = 0; trap_irq = 0; mret_req = 0; sret_req = 0;
  endtask

  task automatic priv_is(input logic [1:0] exp, input string tag);
    #0 chk({tag, " priv"}, XLEN'(priv_o), XLEN'(exp));
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    priv_is(2'b11, "R1");
    chk("R1 redirect_valid idle", XLEN'(redirect_valid), 0);
    rd(12'h300, 0, "R1 mstatus");
    rd(12'h341, 0, "R1 mepc");
    rd(12'h142, 0, "R1 scause");
  endtask

  task automatic t_setup;
    wr(12'h305, 32'h101);
    wr(12'h105, 32'h203);
    wr(12'h302, 32'h100);
    wr(12'h303, 32'h20);
    wr(12'h300, 32'h8);
  endtask

  task automatic t_m_irq;   // R4 R12: delegated cause taken in M stays in M
    ev(1, 1, 5, 32'h1000, 32'hAA, 0, 0, 32'h100, "R4 R12 irq in M");
    priv_is(2'b11, "R4");
    rd(12'h342, 32'h8000_0005, "R4 mcause");
    rd(12'h341, 32'h1000, "R4 mepc");
    rd(12'h343, 32'hAA, "R4 mtval");
    rd(12'h300, 32'h1880, "R4 mstatus stack");
  endtask

  task automatic t_mret;    // R6
    ev(0, 0, 0, 32'h1010, 0, 1, 0, 32'h1000, "R6 mret");
    priv_is(2'b11, "R6 to MPP=M");
    rd(12'h300, 32'h88, "R6 mstatus");
  endtask

  task automatic t_mpp_warl; // R9
    wr(12'h300, 32'h1088);
    rd(12'h300, 32'h88, "R9 reserved MPP kept");
    wr(12'h300, 32'h888);
    rd(12'h300, 32'h888, "R9 MPP=S accepted");
    ev(0, 0, 0, 32'h1020, 0, 1, 0, 32'h1000, "R6 mret to S");
    priv_is(2'b01, "R6 to S");
    rd(12'h300, 32'h88, "R6 mstatus after");
  endtask

  task automatic t_sret_to_u; // R7
    wr(12'h141, 32'h4000);
    ev(0, 0, 0, 32'h3000, 0, 0, 1, 32'h4000, "R7 sret S->U");
    priv_is(2'b00, "R7");
    rd(12'h300, 32'hA8, "R7 mstatus");
  endtask

  task automatic t_u_ecall;  // R2 R3 R5
    ev(1, 0, 8, 32'h5000, 32'h77, 0, 0, 32'h200, "R2 R12 U exc delegated");
    priv_is(2'b01, "R2");
    rd(12'h141, 32'h5000, "R2 sepc");
    rd(12'h142, 32'h8, "R2 scause");
    rd(12'h143, 32'h77, "R2 stval");
    rd(12'h300, 32'h88, "R5 SPP=0 SPIE=0");
    rd(12'h341, 32'h1000, "R3 mepc kept");
    rd(12'h342, 32'h8000_0005, "R3 mcause kept");
  endtask

  task automatic t_tsr;      // R8
    wr(12'h300, 32'h40_0088);
    ev(0, 0, 0, 32'h5100, 32'h99, 0, 1, 32'h100, "R8 sret with TSR");
    priv_is(2'b11, "R8");
    rd(12'h342, 32'h2, "R8 mcause illegal");
    rd(12'h341, 32'h5100, "R8 mepc");
    rd(12'h343, 32'h0, "R8 mtval zero");
    rd(12'h300, 32'h40_0880, "R8 mstatus");
  endtask

  task automatic t_sret_m_u; // R7 R8
    ev(0, 0, 0, 32'h6000, 0, 0, 1, 32'h5000, "R7 sret from M");
    priv_is(2'b00, "R7 from M");
    rd(12'h300, 32'h40_08A0, "R7 mstatus");
    ev(0, 0, 0, 32'h7000, 0, 0, 1, 32'h100, "R8 sret in U");
    priv_is(2'b11, "R8 U");
    rd(12'h341, 32'h7000, "R8 mepc U");
    rd(12'h300, 32'h40_0020, "R8 mstatus U");
  endtask

  task automatic t_u_irq;    // R2 R3 R4 R5
    ev(0, 0, 0, 32'h7100, 0, 1, 0, 32'h7000, "R6 mret to U");
    priv_is(2'b00, "R6 U");
    rd(12'h300, 32'h40_00A0, "R6 mstatus U");
    ev(1, 1, 5, 32'h8000, 32'h55, 0, 0, 32'h200, "R2 U irq delegated");
    priv_is(2'b01, "R2 irq");
    rd(12'h142, 32'h8000_0005, "R2 scause irq");
    rd(12'h341, 32'h7000, "R3 mepc kept irq");
    rd(12'h300, 32'h40_0080, "R5 SPIE from SIE");
    ev(1, 0, 3, 32'h9000, 32'h33, 0, 0, 32'h100, "R4 S exc undelegated");
    priv_is(2'b11, "R4 S");
    rd(12'h300, 32'h40_0800, "R4 MPP=S");
    rd(12'h343, 32'h33, "R4 mtval");
    ev(0, 0, 0, 32'h9100, 0, 1, 0, 32'h9000, "R6 back to S");
    priv_is(2'b01, "R6 S");
  endtask

  task automatic t_s_self;   // R5 R7
    ev(1, 0, 8, 32'hA000, 32'h0, 0, 0, 32'h200, "R5 S exc delegated");
    priv_is(2'b01, "R5");
    rd(12'h300, 32'h40_0180, "R5 SPP=1");
    wr(12'h300, 32'h180);
    ev(0, 0, 0, 32'hA100, 0, 0, 1, 32'hA000, "R7 sret S->S");
    priv_is(2'b01, "R7 SPP=1");
    rd(12'h300, 32'hA0, "R7 mstatus S");
  endtask

  task automatic t_precedence; // R11
    @(negedge clk);
    trap_req = 1; trap_cause = 5'd3; evt_pc = 32'hB000; trap_tval = 32'h11;
    sret_req = 1; csr_we = 1; csr_addr = 12'h305; csr_wdata = 32'hDEAD_0000;
    #1 chk("R11 trap wins redirect", redirect_pc, 32'h100);
    @(posedge clk); #1;
    trap_req = 0; sret_req = 0; csr_we = 0;
    priv_is(2'b11, "R11");
    rd(12'h305, 32'h101, "R11 write dropped");
    rd(12'h141, 32'hA000, "R11 sret ignored");
    rd(12'h300, 32'h820, "R11 mstatus");
  endtask

  task automatic t_mret_in_s; // R8 R2
    ev(0, 0, 0, 32'hB100, 0, 1, 0, 32'hB000, "R6 mret to S again");
    wr(12'h302, 32'h104);
    rd(12'h302, 32'h104, "R2 mask readback");
    ev(0, 0, 0, 32'hC000, 0, 1, 0, 32'h200, "R8 mret in S delegated");
    priv_is(2'b01, "R8 S");
    rd(12'h142, 32'h2, "R8 scause");
    rd(12'h141, 32'hC000, "R8 sepc");
    rd(12'h341, 32'hB000, "R3 mepc kept");
    rd(12'h300, 32'h180, "R8 mstatus");
  endtask

  task automatic t_sstatus;  // R10
    rd(12'h100, 32'h100, "R10 sstatus view");
    wr(12'h100, 32'hFFFF_FFFF);
    rd(12'h300, 32'h1A2, "R10 only S bits written");
    rd(12'h100, 32'h122, "R10 sstatus readback");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset;
    t_setup;
    t_m_irq;
    t_mret;
    t_mpp_warl;
    t_sret_to_u;
    t_u_ecall;
    t_tsr;
    t_sret_m_u;
    t_u_irq;
    t_s_self;
    t_precedence;
    t_mret_in_s;
    t_sstatus;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule